// File: doc/BRIEF.md
# Audio/Video Switch Control Register Slave

This block is the serial control port of an audio/video switch. It is an I2C slave that sits on an already synchronised SCL/SDA pair and keeps the switch's whole configuration in registers. The configuration covers volume, mute, source selects, blanking mode, function-switch mode, Y/C mix and four logic outputs. Each field is decoded onto its own output bus, so the analog side can use it directly.

A write carries no register pointer. After the address byte, the master sends exactly five data bytes, and each byte lands in a fixed slot. Each byte is committed when the slave acknowledges it. The TV mute control appears in two of these bytes. Both copies feed one register, so whichever byte arrived last decides the mute state.

A read returns one packed status byte. That byte is built from the zero-cross flag, the power-on flag and the two function-level inputs. The low bit of the 7-bit address comes from a strap pin.

Top module: `avsw_ctrl_slave`

## Requirements
- R1: While reset is high and in the cycle after, every configuration output is zero (fast-blank mode 00 = forced low, function mode 00 = internal TV) and `sda_oe` is 0.
- R2: The slave answers only the 7-bit address `100100` followed by `addr_sel` (8-bit write address 0x90 with the strap low, 0x92 with it high). On any other address it leaves SDA released for the acknowledge bit and ignores the rest of the transaction.
- R3: The first data byte sets `vol_coarse` from bits 7:5, `vol_fine` from bits 4:2, `tv_mute` from bit 1 and `zc_en` from bit 0.
- R4: The second data byte sets `fblank_mode` from bits 7:6, `tv_vid_sel` from bits 5:3 and `tv_aud_sel` from bits 2:0.
- R5: The third data byte sets `fn_mode` from bits 7:6, `vcr_vid_sel` from bits 5:3 and `vcr_aud_sel` from bits 2:0.
- R6: The fourth data byte sets `yc_mix_en` from bit 7, `aux_vid_sel` from bits 5:3 and `aux_aud_sel` from bits 2:0. Bit 6 is ignored.
- R7: The fifth data byte sets `tv_mute` from bit 7 and `logic_sink[3:0]` from bits 3:0. Bit 0 drives the first logic output, and a 1 means sink current. Bits 6:4 are ignored.
- R8: Each of the five data bytes of a write is acknowledged, by driving `sda_oe` high during its ninth clock. A sixth byte is not acknowledged and changes nothing. Configuration outputs change only while SCL is low.
- R9: `tv_mute` is one register written by both copies. Its value is the mute bit of the most recently acknowledged first or fifth byte.
- R10: A read (address LSB = 1) returns `{2'b00, zc_status, pod_flag, aux_fn_lvl[1:0], vcr_fn_lvl[1:0]}`, MSB first. The slave samples this byte at the address acknowledge. It releases SDA for the master's acknowledge bit. The slave raises `sda_oe` only while SCL is low.
- R11: A STOP or repeated START in the middle of a transaction aborts it. Bytes already acknowledged stay committed, a partly received byte is discarded, and `sda_oe` is 0 in the cycle after a STOP.
- R12: `sda_oe` does not change while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Synchronised SCL level |
| sda_i | input | 1 | Synchronised SDA bus level |
| sda_oe | output | 1 | 1 pulls SDA low |
| addr_sel | input | 1 | Address strap, low address bit |
| zc_status | input | 1 | Zero-cross reached flag for status |
| pod_flag | input | 1 | Power-on-detect flag for status |
| aux_fn_lvl | input | 2 | AUX function-pin level code |
| vcr_fn_lvl | input | 2 | VCR function-pin level code |
| vol_coarse | output | 3 | Coarse attenuation step (8 dB units) |
| vol_fine | output | 3 | Fine attenuation step (1 dB units) |
| tv_mute | output | 1 | TV audio mute |
| zc_en | output | 1 | Apply volume/mute at zero cross |
| fblank_mode | output | 2 | Fast-blank output mode |
| tv_vid_sel | output | 3 | TV video source select |
| tv_aud_sel | output | 3 | TV audio source select |
| fn_mode | output | 2 | TV function-switch mode |
| vcr_vid_sel | output | 3 | VCR video source select |
| vcr_aud_sel | output | 3 | VCR audio source select |
| yc_mix_en | output | 1 | Y/C mix for the modulator output |
| aux_vid_sel | output | 3 | AUX video source select |
| aux_aud_sel | output | 3 | AUX audio source select |
| logic_sink | output | 4 | Logic outputs, 1 = sink |

## Verification
If the byte counter is wrong, the wrong output group moves. It can also show as a missing acknowledge at the ninth clock of some byte, and that shows up at the end of that same byte. A wrong phase, or a wrong bit count in the shift logic, shifts every field of a committed byte by one position. It can also leave SDA held low into the next bit. Either fault is visible on the outputs within two system clocks of the acknowledging SCL fall. A mis-decoded abort leaves the fields of a partial byte changed after the STOP, or leaves the slave unable to answer the next START.

// File: rtl/avsw_pkg.sv
package avsw_pkg;

    localparam int NBYTES    = 5;
    localparam int BYTE_W    = 8;
    localparam int IDX_W     = $clog2(NBYTES + 1);
    localparam int BITCNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_AACK,
        PH_WR,
        PH_WACK,
        PH_RD,
        PH_RACK
    } phase_t;

    typedef struct packed {
        logic start;
        logic stop;
        logic rise;
        logic fall;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic [2:0] vol_coarse;
        logic [2:0] vol_fine;
        logic       tv_mute;
        logic       zc_en;
        logic [1:0] fblank_mode;
        logic [2:0] tv_vid_sel;
        logic [2:0] tv_aud_sel;
        logic [1:0] fn_mode;
        logic [2:0] vcr_vid_sel;
        logic [2:0] vcr_aud_sel;
        logic       yc_mix_en;
        logic [2:0] aux_vid_sel;
        logic [2:0] aux_aud_sel;
        logic [3:0] logic_sink;
    } cfg_t;

    localparam cfg_t CFG_RESET = '0;

    function automatic logic [BYTE_W-1:0] pack_status(
        input logic       zc,
        input logic       pod,
        input logic [1:0] aux_lvl,
        input logic [1:0] vcr_lvl
    );
        return {2'b00, zc, pod, aux_lvl, vcr_lvl};
    endfunction

    function automatic cfg_t apply_byte(
        input cfg_t              cur,
        input logic [IDX_W-1:0]  idx,
        input logic [BYTE_W-1:0] d
    );
        cfg_t nxt;
        nxt = cur;
        case (idx)
            3'd0: begin
                nxt.vol_coarse = d[7:5];
                nxt.vol_fine   = d[4:2];
                nxt.tv_mute    = d[1];
                nxt.zc_en      = d[0];
            end
            3'd1: begin
                nxt.fblank_mode = d[7:6];
                nxt.tv_vid_sel  = d[5:3];
                nxt.tv_aud_sel  = d[2:0];
            end
            3'd2: begin
                nxt.fn_mode     = d[7:6];
                nxt.vcr_vid_sel = d[5:3];
                nxt.vcr_aud_sel = d[2:0];
            end
            3'd3: begin
                nxt.yc_mix_en   = d[7];
                nxt.aux_vid_sel = d[5:3];
                nxt.aux_aud_sel = d[2:0];
            end
            3'd4: begin
                nxt.tv_mute    = d[7];
                nxt.logic_sink = d[3:0];
            end
            default: ;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/avsw_bus_events.sv
module avsw_bus_events
    import avsw_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        ev.start = scl_i && scl_q && sda_q && !sda_i;
        ev.stop  = scl_i && scl_q && !sda_q && sda_i;
        ev.rise  = scl_i && !scl_q;
        ev.fall  = !scl_i && scl_q;
        ev.sda   = sda_i;
    end

endmodule

// File: rtl/avsw_i2c_engine.sv
module avsw_i2c_engine
    import avsw_pkg::*;
#(
    parameter logic [5:0] ADDR_PREFIX = 6'b100100
)
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic              addr_sel,
    input  logic [BYTE_W-1:0] status_byte,
    output logic              sda_oe,
    output logic              wr_stb,
    output logic [IDX_W-1:0]  wr_idx,
    output logic [BYTE_W-1:0] wr_data
);

    phase_t              phase;
    logic [BITCNT_W-1:0] bitcnt;
    logic [BYTE_W-1:0]   rx_sh;
    logic [BYTE_W-1:0]   tx_sh;
    logic [IDX_W-1:0]    byte_idx;
    logic                rd_mode;
    logic                master_ack;

    localparam logic [BITCNT_W-1:0] FULL = BITCNT_W'(BYTE_W);
    localparam logic [BITCNT_W-1:0] LAST = BITCNT_W'(BYTE_W - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_IDLE;
            bitcnt     <= '0;
            rx_sh      <= '0;
            tx_sh      <= '0;
            byte_idx   <= '0;
            rd_mode    <= 1'b0;
            master_ack <= 1'b0;
            wr_stb     <= 1'b0;
            wr_idx     <= '0;
            wr_data    <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (ev.stop) begin
                phase <= PH_IDLE;
            end else if (ev.start) begin
                phase  <= PH_ADDR;
                bitcnt <= '0;
            end else begin
                case (phase)
                    PH_ADDR: begin
                        if (ev.rise) begin
                            rx_sh  <= {rx_sh[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == FULL) begin
                            if (rx_sh[7:1] == {ADDR_PREFIX, addr_sel}) begin
                                phase   <= PH_AACK;
                                rd_mode <= rx_sh[0];
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_AACK: begin
                        if (ev.fall) begin
                            bitcnt <= '0;
                            if (rd_mode) begin
                                tx_sh <= status_byte;
                                phase <= PH_RD;
                            end else begin
                                byte_idx <= '0;
                                phase    <= PH_WR;
                            end
                        end
                    end
                    PH_WR: begin
                        if (ev.rise) begin
                            rx_sh  <= {rx_sh[BYTE_W-2:0], ev.sda};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (ev.fall && bitcnt == FULL) begin
                            if (int'(byte_idx) < NBYTES) begin
                                wr_stb  <= 1'b1;
                                wr_idx  <= byte_idx;
                                wr_data <= rx_sh;
                                phase   <= PH_WACK;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    PH_WACK: begin
                        if (ev.fall) begin
                            byte_idx <= byte_idx + 1'b1;
                            bitcnt   <= '0;
                            phase    <= PH_WR;
                        end
                    end
                    PH_RD: begin
                        if (ev.fall) begin
                            if (bitcnt == LAST) begin
                                phase <= PH_RACK;
                            end else begin
                                tx_sh  <= {tx_sh[BYTE_W-2:0], 1'b0};
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                    PH_RACK: begin
                        if (ev.rise) begin
                            master_ack <= !ev.sda;
                        end else if (ev.fall) begin
                            if (master_ack) begin
                                tx_sh  <= status_byte;
                                bitcnt <= '0;
                                phase  <= PH_RD;
                            end else begin
                                phase <= PH_IDLE;
                            end
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    always_comb begin
        case (phase)
            PH_AACK, PH_WACK: sda_oe = 1'b1;
            PH_RD:            sda_oe = !tx_sh[BYTE_W-1];
            default:          sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/avsw_cfg_regs.sv
module avsw_cfg_regs
    import avsw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wr_data,
    output cfg_t              cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr_stb) begin
            cfg <= apply_byte(cfg, wr_idx, wr_data);
        end
    end

endmodule

// File: rtl/avsw_ctrl_slave.sv
module avsw_ctrl_slave
    import avsw_pkg::*;
#(
    parameter logic [5:0] ADDR_PREFIX = 6'b100100
)
(
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       addr_sel,
    input  logic       zc_status,
    input  logic       pod_flag,
    input  logic [1:0] aux_fn_lvl,
    input  logic [1:0] vcr_fn_lvl,
    output logic [2:0] vol_coarse,
    output logic [2:0] vol_fine,
    output logic       tv_mute,
    output logic       zc_en,
    output logic [1:0] fblank_mode,
    output logic [2:0] tv_vid_sel,
    output logic [2:0] tv_aud_sel,
    output logic [1:0] fn_mode,
    output logic [2:0] vcr_vid_sel,
    output logic [2:0] vcr_aud_sel,
    output logic       yc_mix_en,
    output logic [2:0] aux_vid_sel,
    output logic [2:0] aux_aud_sel,
    output logic [3:0] logic_sink
);

    bus_ev_t           ev;
    logic              wr_stb;
    logic [IDX_W-1:0]  wr_idx;
    logic [BYTE_W-1:0] wr_data;
    logic [BYTE_W-1:0] status_byte;
    cfg_t              cfg_q;

    assign status_byte = pack_status(zc_status, pod_flag, aux_fn_lvl, vcr_fn_lvl);

    avsw_bus_events u_ev (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    avsw_i2c_engine #(.ADDR_PREFIX(ADDR_PREFIX)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .ev          (ev),
        .addr_sel    (addr_sel),
        .status_byte (status_byte),
        .sda_oe      (sda_oe),
        .wr_stb      (wr_stb),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data)
    );

    avsw_cfg_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_stb  (wr_stb),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cfg     (cfg_q)
    );

    assign vol_coarse  = cfg_q.vol_coarse;
    assign vol_fine    = cfg_q.vol_fine;
    assign tv_mute     = cfg_q.tv_mute;
    assign zc_en       = cfg_q.zc_en;
    assign fblank_mode = cfg_q.fblank_mode;
    assign tv_vid_sel  = cfg_q.tv_vid_sel;
    assign tv_aud_sel  = cfg_q.tv_aud_sel;
    assign fn_mode     = cfg_q.fn_mode;
    assign vcr_vid_sel = cfg_q.vcr_vid_sel;
    assign vcr_aud_sel = cfg_q.vcr_aud_sel;
    assign yc_mix_en   = cfg_q.yc_mix_en;
    assign aux_vid_sel = cfg_q.aux_vid_sel;
    assign aux_aud_sel = cfg_q.aux_aud_sel;
    assign logic_sink  = cfg_q.logic_sink;

endmodule

// File: rtl/avsw_ctrl_chk.sv
module avsw_ctrl_chk
    import avsw_pkg::*;
(
    input logic clk,
    input logic rst,
    input logic scl_i,
    input logic sda_i,
    input logic sda_oe,
    input cfg_t cfg
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (cfg == CFG_RESET && !sda_oe));

    // R12
    oe_steady_scl_high_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe));

    // R10
    oe_rises_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R8
    cfg_moves_scl_low_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> !scl_i);

    // R11
    stop_releases_chk: assert property (@(posedge clk) disable iff (rst)
        (scl_i && $past(scl_i) && sda_i && !$past(sda_i)) |=> !sda_oe);

endmodule

bind avsw_ctrl_slave avsw_ctrl_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .scl_i  (scl_i),
    .sda_i  (sda_i),
    .sda_oe (sda_oe),
    .cfg    (cfg_q)
);

// File: tb/tb_avsw_ctrl_slave.sv
module tb_avsw_ctrl_slave;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0;
    logic zc_status = 1'b0, pod_flag = 1'b0;
    logic [1:0] aux_fn_lvl = 2'b00, vcr_fn_lvl = 2'b00;
    logic sda_oe, sda_bus;
    logic [2:0] vol_coarse, vol_fine, tv_vid_sel, tv_aud_sel;
    logic [2:0] vcr_vid_sel, vcr_aud_sel, aux_vid_sel, aux_aud_sel;
    logic [1:0] fblank_mode, fn_mode;
    logic tv_mute, zc_en, yc_mix_en;
    logic [3:0] logic_sink;

    assign sda_bus = sda_m & ~sda_oe;

    avsw_ctrl_slave dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
        .addr_sel(addr_sel), .zc_status(zc_status), .pod_flag(pod_flag),
        .aux_fn_lvl(aux_fn_lvl), .vcr_fn_lvl(vcr_fn_lvl),
        .vol_coarse(vol_coarse), .vol_fine(vol_fine), .tv_mute(tv_mute),
        .zc_en(zc_en), .fblank_mode(fblank_mode), .tv_vid_sel(tv_vid_sel),
        .tv_aud_sel(tv_aud_sel), .fn_mode(fn_mode), .vcr_vid_sel(vcr_vid_sel),
        .vcr_aud_sel(vcr_aud_sel), .yc_mix_en(yc_mix_en),
        .aux_vid_sel(aux_vid_sel), .aux_aud_sel(aux_aud_sel),
        .logic_sink(logic_sink)
    );

    // {addr_sel, DATA1 .. DATA5}
    localparam logic [40:0] VEC [5] = '{
        41'h0_A5_3C_C7_E9_8F,
        41'h1_FF_FF_FF_FF_FF,
        41'h0_00_00_00_00_00,
        41'h1_5A_96_69_2A_05,
        41'h0_E2_41_B2_9B_70
    };

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;
    logic [7:0] sb [5];
    logic smute;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic w();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; w(); scl_m = 1'b1; w(); sda_m = 1'b0; w(); scl_m = 1'b0; w();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; w(); scl_m = 1'b1; w(); sda_m = 1'b1; w();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; w(); scl_m = 1'b1; w(); w(); scl_m = 1'b0; w();
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; w(); scl_m = 1'b1; w(); b = sda_bus; w(); scl_m = 1'b0; w();
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        logic a;
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        get_bit(a);
        ack = !a;
    endtask

    task automatic get_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            d[i] = b;
        end
        put_bit(!mack);
    endtask

    task automatic open_write(input logic asel);
        logic ack;
        addr_sel = asel;
        bus_start();
        put_byte({6'b100100, asel, 1'b0}, ack);
        chk("R2 write address ack", 32'(ack), 32'd1);
    endtask

    task automatic send_data(input int idx, input logic [7:0] d);
        logic ack;
        put_byte(d, ack);
        chk("R8 data byte ack", 32'(ack), 32'(idx < 5));
        if (idx < 5) begin
            sb[idx] = d;
            if (idx == 0) smute = d[1];
            if (idx == 4) smute = d[7];
        end
    endtask

    task automatic write_all(input logic [40:0] v);
        open_write(v[40]);
        for (int i = 0; i < 5; i++) send_data(i, v[39-8*i -: 8]);
        bus_stop();
    endtask

    task automatic check_cfg();
        chk("R3 vol_coarse", 32'(vol_coarse), 32'(sb[0][7:5]));
        chk("R3 vol_fine", 32'(vol_fine), 32'(sb[0][4:2]));
        chk("R3 zc_en", 32'(zc_en), 32'(sb[0][0]));
        chk("R9 tv_mute", 32'(tv_mute), 32'(smute));
        chk("R4 fblank_mode", 32'(fblank_mode), 32'(sb[1][7:6]));
        chk("R4 tv_vid_sel", 32'(tv_vid_sel), 32'(sb[1][5:3]));
        chk("R4 tv_aud_sel", 32'(tv_aud_sel), 32'(sb[1][2:0]));
        chk("R5 fn_mode", 32'(fn_mode), 32'(sb[2][7:6]));
        chk("R5 vcr_vid_sel", 32'(vcr_vid_sel), 32'(sb[2][5:3]));
        chk("R5 vcr_aud_sel", 32'(vcr_aud_sel), 32'(sb[2][2:0]));
        chk("R6 yc_mix_en", 32'(yc_mix_en), 32'(sb[3][7]));
        chk("R6 aux_vid_sel", 32'(aux_vid_sel), 32'(sb[3][5:3]));
        chk("R6 aux_aud_sel", 32'(aux_aud_sel), 32'(sb[3][2:0]));
        chk("R7 logic_sink", 32'(logic_sink), 32'(sb[4][3:0]));
    endtask

    task automatic read_status(input logic asel, input logic [7:0] exp);
        logic ack;
        logic [7:0] d;
        addr_sel = asel;
        bus_start();
        put_byte({6'b100100, asel, 1'b1}, ack);
        chk("R2 read address ack", 32'(ack), 32'd1);
        get_byte(d, 1'b0);
        chk("R10 status byte", 32'(d), 32'(exp));
        chk("R10 released after byte", 32'(sda_oe), 32'd0);
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic ack;
        for (int i = 0; i < 5; i++) sb[i] = 8'h00;
        smute = 1'b0;
        repeat (5) @(negedge clk);
        // R1 state held during reset
        chk("R1 sda_oe in reset", 32'(sda_oe), 32'd0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check_cfg();
        chk("R1 fblank forced low", 32'(fblank_mode), 32'd0);
        chk("R1 fn internal", 32'(fn_mode), 32'd0);

        // vector walk
        for (int v = 0; v < 5; v++) begin
            write_all(VEC[v]);
            check_cfg();
        end

        // R2 wrong address: 0x92 with strap low, 0x90 with strap high
        addr_sel = 1'b0;
        bus_start();
        put_byte(8'h92, ack);
        chk("R2 no ack on foreign address", 32'(ack), 32'd0);
        put_byte(8'hFF, ack);
        chk("R2 ignored byte no ack", 32'(ack), 32'd0);
        bus_stop();
        check_cfg();
        addr_sel = 1'b1;
        bus_start();
        put_byte(8'h90, ack);
        chk("R2 no ack on 0x90 with strap high", 32'(ack), 32'd0);
        bus_stop();
        check_cfg();

        // R8 sixth byte refused and ignored
        open_write(1'b0);
        send_data(0, 8'h24);
        send_data(1, 8'h4B);
        send_data(2, 8'h9D);
        send_data(3, 8'h12);
        send_data(4, 8'h0A);
        send_data(5, 8'hFF);
        bus_stop();
        check_cfg();

        // R9 mute last byte wins, both orders
        write_all(41'h0_02_00_00_00_00);
        chk("R9 DATA5 clear wins", 32'(tv_mute), 32'd0);
        write_all(41'h1_00_00_00_00_80);
        chk("R9 DATA5 set wins", 32'(tv_mute), 32'd1);
        open_write(1'b1);
        send_data(0, 8'h00);
        bus_stop();
        chk("R9 later DATA1 clear wins", 32'(tv_mute), 32'd0);
        check_cfg();

        // R11 stop mid byte: two bytes kept, partial third discarded
        write_all(41'h0_11_22_33_44_55);
        open_write(1'b0);
        send_data(0, 8'hEE);
        send_data(1, 8'hC9);
        put_bit(1'b1); put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
        bus_stop();
        repeat (2) @(negedge clk);
        chk("R11 released after stop", 32'(sda_oe), 32'd0);
        check_cfg();

        // R11 repeated start mid write, then status read in same transfer
        zc_status = 1'b1; pod_flag = 1'b0; aux_fn_lvl = 2'b10; vcr_fn_lvl = 2'b01;
        open_write(1'b0);
        send_data(0, 8'h6B);
        put_bit(1'b0); put_bit(1'b1);
        bus_start();
        put_byte(8'h91, ack);
        chk("R11 repeated start read ack", 32'(ack), 32'd1);
        begin
            logic [7:0] d;
            get_byte(d, 1'b0);
            chk("R10 status after repeated start", 32'(d), 32'h29);
        end
        bus_stop();
        check_cfg();

        // R10 read with strap high, other status pattern
        zc_status = 1'b0; pod_flag = 1'b1; aux_fn_lvl = 2'b11; vcr_fn_lvl = 2'b00;
        read_status(1'b1, 8'h1C);
        zc_status = 1'b1; pod_flag = 1'b1; aux_fn_lvl = 2'b01; vcr_fn_lvl = 2'b11;
        read_status(1'b0, 8'h37);
        check_cfg();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule